// File: doc/BRIEF.md
# Asynchronous Request Header Formatter

This block sits between a host transmit queue and a serial link transmitter. The host hands over a read request as three 32-bit quadlets in its own layout. The block moves the fields into the on-wire header layout and puts the local node's source ID into the second header quadlet. After the three header quadlets it appends a 32-bit CRC, computed over the rewritten header.

Both sides are quadlet streams with a valid/ready handshake. The output also carries a last flag that marks the CRC quadlet. The host's speed code is taken out of the header and held on a side output for the transmitter for as long as the packet is being sent. The node ID is a static input. The block handles only the header; data payloads, arbitration and byte serialisation belong to other blocks.

Bit 31 is the most significant bit of every quadlet. In the host layout, the first quadlet carries the speed code in bits 17:16 and the packed label, retry code, transaction code and priority in bits 15:0. The second host quadlet carries the destination ID in bits 31:16 and the top 16 bits of the destination offset in bits 15:0. The third host quadlet carries the low 32 offset bits.

Top module: `txhdr_formatter`

## Requirements
- R1: A synchronous active-low reset empties the output (`out_valid`=0, `out_last`=0) and leaves the block ready to accept the first host quadlet (`in_ready`=1).
- R2: The first output quadlet is {host quadlet 1 bits 31:16, host quadlet 0 bits 15:0}, which is the destination ID followed by label, retry code, transaction code and priority.
- R3: The second output quadlet is {`node_id`, host quadlet 1 bits 15:0}.
- R4: The third output quadlet equals host quadlet 2 unchanged.
- R5: The fourth output quadlet is a CRC over output quadlets one to three. The register starts at 0xFFFFFFFF and takes bits MSB first. For each bit, the input bit is XORed with the register's bit 31, the register shifts left by one, and 0x04C11DB7 is XORed in when that XOR was 1. The result is sent with no inversion and no bit reflection.
- R6: `out_last` is 1 on the fourth (CRC) quadlet of each packet and 0 on the other three.
- R7: `out_speed` equals host quadlet 0 bits 17:16 and does not change while any quadlet of that packet is valid on the output.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R9: `in_ready` is 0 in every cycle in which the CRC quadlet is valid on the output and not yet taken.
- R10: A reset in the middle of a packet discards the partial packet and reloads the CRC register with all ones, so the next packet comes out complete and with a correct CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| node_id | input | 16 | Local node ID placed into the header |
| in_valid | input | 1 | Host quadlet valid |
| in_ready | output | 1 | Block accepts a host quadlet |
| in_data | input | 32 | Host quadlet |
| out_valid | output | 1 | Output quadlet valid |
| out_ready | input | 1 | Transmitter accepts the output quadlet |
| out_data | output | 32 | Wire header or CRC quadlet |
| out_last | output | 1 | Marks the CRC quadlet |
| out_speed | output | 2 | Speed code of the current packet |

## Verification
The in-line assertions check these properties on every cycle:
- the output holds steady under backpressure;
- the input is blocked while the CRC quadlet is waiting;
- the speed output stays stable across consecutive valid cycles;
- the last flag lands on the fourth handshaken quadlet of each packet, and never earlier.

Other properties only the bench scenarios can show, against a behavioural model of the packets it sends:
- the field moves between quadlets;
- the source-ID insertion;
- the exact CRC value;
- recovery from a reset that cuts a packet off partway.

The bench runs these scenarios with no backpressure, with random backpressure, and with back-to-back packets.

// File: rtl/txhdr_pkg.sv
// Package: shared constants, types and the quadlet-wide CRC step.
// Assumes bit 31 of a quadlet is its most significant bit and is sent first.
package txhdr_pkg;

    localparam int          QUAD_W   = 32;
    localparam int          NODE_W   = 16;
    localparam int          SPD_W    = 2;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    // Sequencer states: waiting on a host quadlet, or on output space
    typedef enum logic [2:0] {
        ST_HOST0 = 3'd0,
        ST_HOST1 = 3'd1,
        ST_WIRE1 = 3'd2,
        ST_HOST2 = 3'd3,
        ST_CRC   = 3'd4
    } fmt_state_e;

    // Which output quadlet the remap stage produces
    typedef enum logic [1:0] {
        SEL_WIRE0 = 2'd0,
        SEL_WIRE1 = 2'd1,
        SEL_WIRE2 = 2'd2,
        SEL_CRC   = 2'd3
    } wsel_e;

    // Advances the CRC by one whole quadlet, MSB first, unrolled over 32 bits
    function automatic logic [31:0] crc_quad(input logic [31:0] crc_in,
                                             input logic [31:0] data);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ data[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/txhdr_crc.sv
// Module: header CRC register.
// Updates by one quadlet per cycle when update is high; clear (or reset)
// reloads the initial value. Assumes clear and update are never both high.
module txhdr_crc
    import txhdr_pkg::*;
#(
    parameter int          W    = QUAD_W,
    parameter logic [31:0] INIT = CRC_INIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         update,
    input  logic [W-1:0] data,
    output logic [W-1:0] crc
);

    // Accumulates the running CRC over header quadlets
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= INIT[W-1:0];
        else if (update)     crc <= crc_quad(crc, data);
    end

endmodule

// File: rtl/txhdr_remap.sv
// Module: combinational field remap from host layout to wire layout.
// Assumes the host's first quadlet low half and the offset high half were
// captured earlier; the live input supplies the destination ID and low offset.
module txhdr_remap
    import txhdr_pkg::*;
#(
    parameter int W  = QUAD_W,
    parameter int NW = NODE_W
) (
    input  wsel_e        sel,
    input  logic [W-1:0] in_word,
    input  logic [NW-1:0] node_id,
    input  logic [W-NW-1:0] ctl_fields,
    input  logic [W-NW-1:0] off_hi,
    input  logic [W-1:0] crc,
    output logic [W-1:0] wire_word
);

    // Selects and packs the quadlet for the current header position
    always_comb begin
        unique case (sel)
            SEL_WIRE0: wire_word = {in_word[W-1:W-NW], ctl_fields};
            SEL_WIRE1: wire_word = {node_id, off_hi};
            SEL_WIRE2: wire_word = in_word;
            default:   wire_word = crc;
        endcase
    end

endmodule

// File: rtl/txhdr_formatter.sv
// Module: async request header formatter (top).
// Accepts three host quadlets and emits three wire header quadlets, then
// the CRC quadlet with out_last. It has one registered output stage.
// Assumes node_id is static during a packet.
module txhdr_formatter
    import txhdr_pkg::*;
#(
    parameter int W  = QUAD_W,
    parameter int NW = NODE_W,
    parameter int SW = SPD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] node_id,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_data,
    output logic          out_last,
    output logic [SW-1:0] out_speed
);

    localparam int LOW_W = W - NW;

    fmt_state_e      state, state_nxt;
    wsel_e           sel;
    logic            can_load, take, emit;
    logic [LOW_W-1:0] ctl_fields_q, off_hi_q;
    logic [SW-1:0]   speed_q;
    logic [W-1:0]    crc, wire_word;

    assign can_load  = !out_valid || out_ready;
    assign take      = in_valid && in_ready;
    assign out_speed = speed_q;

    // Decides readiness, output emission, remap select and next state
    always_comb begin
        in_ready  = 1'b0;
        emit      = 1'b0;
        sel       = SEL_CRC;
        state_nxt = state;
        unique case (state)
            ST_HOST0: begin
                in_ready = !(out_valid && out_last);
                if (take) state_nxt = ST_HOST1;
            end
            ST_HOST1: begin
                in_ready = can_load;
                sel      = SEL_WIRE0;
                emit     = take;
                if (take) state_nxt = ST_WIRE1;
            end
            ST_WIRE1: begin
                sel  = SEL_WIRE1;
                emit = can_load;
                if (can_load) state_nxt = ST_HOST2;
            end
            ST_HOST2: begin
                in_ready = can_load;
                sel      = SEL_WIRE2;
                emit     = take;
                if (take) state_nxt = ST_CRC;
            end
            default: begin
                sel  = SEL_CRC;
                emit = can_load;
                if (can_load) state_nxt = ST_HOST0;
            end
        endcase
    end

    // Advances the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HOST0;
        else        state <= state_nxt;
    end

    // Captures host fields needed by later wire quadlets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_fields_q <= '0;
            off_hi_q     <= '0;
            speed_q      <= '0;
        end else if (take && state == ST_HOST0) begin
            ctl_fields_q <= in_data[LOW_W-1:0];
            speed_q      <= in_data[LOW_W+SW-1:LOW_W];
        end else if (take && state == ST_HOST1) begin
            off_hi_q     <= in_data[LOW_W-1:0];
        end
    end

    txhdr_remap #(.W(W), .NW(NW)) u_remap (
        .sel        (sel),
        .in_word    (in_data),
        .node_id    (node_id),
        .ctl_fields (ctl_fields_q),
        .off_hi     (off_hi_q),
        .crc        (crc),
        .wire_word  (wire_word)
    );

    txhdr_crc #(.W(W), .INIT(CRC_INIT)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (emit && state == ST_CRC),
        .update (emit && state != ST_CRC),
        .data   (wire_word),
        .crc    (crc)
    );

    // Output register stage with valid/ready hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_last  <= (state == ST_CRC);
            out_data  <= wire_word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end

    // Counts handshaken output beats within a packet for the last-flag check
    logic [1:0] beat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                      beat_cnt <= '0;
        else if (out_valid && out_ready) beat_cnt <= beat_cnt + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_last && state == ST_HOST0));

    assert_last_on_crc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (beat_cnt == 2'd3)));

    assert_speed_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(out_speed));

    assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_no_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> !in_ready);

endmodule

// File: tb/txhdr_formatter_bench.sv
// Bench: behavioural packet model with expected-output queues, compared
// at every output handshake and on every cycle for hold and blocking rules.
module txhdr_formatter_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] NODE = 16'hFFC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;
    logic [1:0]  out_speed;

    int checks = 0;
    int fails  = 0;
    bit bp_mode = 0;
    bit mon_en  = 1;
    bit done    = 0;

    logic [31:0] exp_data[$];
    bit          exp_last[$];
    logic [1:0]  exp_spd[$];
    string       exp_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    txhdr_formatter u_txhdr_formatter (
        .clk(clk), .rst_n(rst_n), .node_id(NODE),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_speed(out_speed)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Reference CRC: walks a bit mask over each quadlet
    function automatic logic [31:0] ref_crc(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [31:0] c);
        logic [31:0] sum;
        logic [31:0] q[3];
        logic [31:0] mask;
        bit top, nb;
        q[0] = a; q[1] = b; q[2] = c;
        sum = 32'hFFFF_FFFF;
        for (int k = 0; k < 3; k++) begin
            mask = 32'h8000_0000;
            while (mask != 0) begin
                nb  = (q[k] & mask) != 0;
                top = sum[31];
                sum = sum << 1;
                if (top ^ nb) sum = sum ^ 32'h04C1_1DB7;
                mask = mask >> 1;
            end
        end
        return sum;
    endfunction

    // Random or full-rate backpressure, changed at negedge
    always @(negedge clk) out_ready <= bp_mode ? ($urandom % 3 != 0) : 1'b1;

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic send_pkt(input logic [1:0] spd, input logic [5:0] tl,
                            input logic [1:0] rt, input logic [3:0] tc,
                            input logic [3:0] pri, input logic [15:0] dest,
                            input logic [47:0] off, input int nwords);
        logic [31:0] h0, h1, h2, w0, w1, w2;
        h0 = {14'h0, spd, tl, rt, tc, pri};
        h1 = {dest, off[47:32]};
        h2 = off[31:0];
        w0 = {dest, tl, rt, tc, pri};
        w1 = {NODE, off[47:32]};
        w2 = off[31:0];
        if (nwords == 3) begin
            exp_data.push_back(w0); exp_last.push_back(0); exp_spd.push_back(spd); exp_req.push_back("R2");
            exp_data.push_back(w1); exp_last.push_back(0); exp_spd.push_back(spd); exp_req.push_back("R3");
            exp_data.push_back(w2); exp_last.push_back(0); exp_spd.push_back(spd); exp_req.push_back("R4");
            exp_data.push_back(ref_crc(w0, w1, w2)); exp_last.push_back(1);
            exp_spd.push_back(spd); exp_req.push_back("R5");
        end
        push_word(h0);
        if (nwords > 1) push_word(h1);
        if (nwords > 2) push_word(h2);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #3;
        // R1: reset state visible at the ports
        chk(!out_valid, "R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk(!out_last,  "R1 out_last",  {31'b0, out_last},  32'd0);
        chk(in_ready,   "R1 in_ready",  {31'b0, in_ready},  32'd1);
        exp_data.delete(); exp_last.delete(); exp_spd.delete(); exp_req.delete();
        rst_n = 1'b1;
    endtask

    // Monitor: hold (R8), blocking (R9) and per-beat comparison
    logic [31:0] prev_data;
    bit prev_last, prev_stall = 0;
    always @(negedge clk) begin
        #2;
        if (!rst_n) prev_stall = 0;
        else begin
            if (prev_stall) begin
                chk(out_valid && out_data == prev_data && out_last == prev_last,
                    "R8 hold", out_data, prev_data);
            end
            if (out_valid && out_last)
                chk(!in_ready, "R9 in_ready", {31'b0, in_ready}, 32'd0);
            if (out_valid && out_ready && mon_en) begin
                if (exp_data.size() == 0) begin
                    chk(0, "R6 unexpected beat", out_data, 32'hx);
                end else begin
                    chk(out_data == exp_data[0], exp_req[0], out_data, exp_data[0]);
                    chk(out_last == exp_last[0], "R6 last", {31'b0, out_last}, {31'b0, exp_last[0]});
                    chk(out_speed == exp_spd[0], "R7 speed", {30'b0, out_speed}, {30'b0, exp_spd[0]});
                    void'(exp_data.pop_front()); void'(exp_last.pop_front());
                    void'(exp_spd.pop_front());  void'(exp_req.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_last  = out_last;
        end
    end

    task automatic drain();
        int n = 0;
        while (exp_data.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        // R5: every expected quadlet of the packet was delivered
        chk(exp_data.size() == 0, "R5 drained", exp_data.size(), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        do_reset();
        // R2..R5 plain: full rate
        send_pkt(2'b10, 6'b010101, 2'b01, 4'h4, 4'h0, 16'hAAAA, 48'h5555_1234_5678, 3);
        drain();
        send_pkt(2'b00, 6'h00, 2'b00, 4'h0, 4'h0, 16'h0000, 48'h0, 3);
        drain();
        send_pkt(2'b11, 6'h3F, 2'b11, 4'hF, 4'hF, 16'hFFFF, 48'hFFFF_FFFF_FFFF, 3);
        drain();
        // R7/R8/R9 under random backpressure, back-to-back packets
        bp_mode = 1;
        for (int p = 0; p < 6; p++)
            send_pkt(p[1:0], 6'(p * 7), p[1:0] ^ 2'b10, 4'(p + 3), 4'(15 - p),
                     16'(16'h1111 * p), {16'(p), 32'hC0DE_0000 | p}, 3);
        drain();
        bp_mode = 0;
        // R10: reset during a partial packet, then a clean packet
        mon_en = 0;
        send_pkt(2'b01, 6'h2A, 2'b10, 4'h1, 4'h2, 16'hBEEF, 48'h0123_4567_89AB, 2);
        repeat (3) @(negedge clk);
        do_reset();
        mon_en = 1;
        send_pkt(2'b01, 6'h15, 2'b01, 4'h9, 4'h3, 16'hC0C0, 48'hABCD_0F0F_F0F0, 3);
        drain();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule